// File: doc/BRIEF.md
# 64-bit Alarm Timer

A free-running 64-bit time counter that is memory mapped on a small register bus. The counter advances by one on each clock in which the tick-enable input is high and no pause is in force. Software can load the full 64-bit value coherently by writing the low word and then the high word. It can read the value coherently by reading the low word, which captures the upper half, and then the high word. A pair of raw read registers returns the live halves with no side effect.

Four compare alarms each hold a 32-bit target. Each alarm is a two-state machine. The states are `ALM_IDLE` and `ALM_ARMED`, and there are four named transitions:

- **arm**: a write to the alarm register, IDLE to ARMED.
- **retarget**: a write while ARMED, ARMED to ARMED.
- **fire**: the target equals counter bits 31:0 while ARMED and no write is present, ARMED to IDLE.
- **cancel**: a disarm write while ARMED, ARMED to IDLE.

A fire sets a sticky raw interrupt bit. Each alarm drives one interrupt output, which is the raw or forced bit gated by its enable bit.

The bus uses byte addresses 8 bits wide. A write happens on a clock edge where `bus_wr_i` is high. Read data is combinational while `bus_rd_i` is high and zero otherwise. The capture side effect of a low-word read takes place on the edge where `bus_rd_i` is high.

Top module: `tmr_alarm_timer`

## Requirements
- R1: After reset, the counter, the write stage, the read hold, all alarms (IDLE), pause, debug-pause enables, raw, enable and force registers read zero, and `irq_o` is zero.
- R2: The counter rises by exactly one per clock edge at which `tick_i` is high and no pause is active, carrying from bit 31 into bit 32.
- R3: A write to 0x04 stages a low word. A following write to 0x00 loads the counter with {written high word, staged low word}. This load takes priority over counting.
- R4: A read of 0x0C returns counter bits 31:0 and captures bits 63:32. A read of 0x08 returns that captured value. Reads of 0x24 and 0x28 return the live bits 63:32 and 31:0 and capture nothing.
- R5: While bit 0 of the pause register (0x30) is 1, the counter holds its value even when `tick_i` is high.
- R6: The counter holds while any bit of 0x2C is 1 and the matching bit of `dbg_active_i` is 1. An active input whose enable bit is 0 does not stop counting.
- R7: A write to 0x10 + 4·k (k = 0..3) stores the target for alarm k and moves it to ARMED. Bit k of 0x20 reads 1 while alarm k is ARMED.
- R8: An ARMED alarm whose target equals counter bits 31:0 fires. On the next edge its armed bit is 0 and bit k of the raw register (0x34) is 1. Bits 63:32 play no part in the compare.
- R9: Writing a 1 to bit k of 0x20 returns alarm k to IDLE without firing, so its raw bit stays 0.
- R10: When an alarm register is written in the same cycle that the alarm matches, the write wins. The alarm stays ARMED with the new target and no fire occurs.
- R11: A raw bit stays 1 until a 1 is written to that bit of 0x34. Writing a 0 leaves the bit unchanged.
- R12: For each k, `irq_o[k]` equals (raw[k] OR force[k]) AND enable[k]. The enable register is 0x38, the force register is 0x3C, and 0x40 reads the same masked vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable for this cycle |
| dbg_active_i | input | DBG_N | Debug-activity flags, one per debug-pause enable bit |
| bus_addr_i | input | 8 | Byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, zero when no read is requested |
| irq_o | output | N_ALARM | Masked interrupt, one per alarm |

## Verification
A counter load, a pause change and an alarm arm each become visible after the edge that accepts the write. An increment appears after the edge that samples `tick_i`. A fire is one edge later than the cycle in which the counter shows the target: the armed bit drops and the raw bit and `irq_o` rise on that edge. The bench drives and samples only at falling edges. It reads the register map after whole bus cycles, and it waits for the fire edge by starting a read transaction, which crosses exactly one rising edge before sampling. The same-cycle write case is built by placing the alarm write in the cycle directly after the tick that makes the counter match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [7:0] OFS_WR_HI    = 8'h00;
    localparam logic [7:0] OFS_WR_LO    = 8'h04;
    localparam logic [7:0] OFS_RD_HI    = 8'h08;
    localparam logic [7:0] OFS_RD_LO    = 8'h0C;
    localparam logic [7:0] OFS_ALARM0   = 8'h10;
    localparam logic [7:0] OFS_ARMED    = 8'h20;
    localparam logic [7:0] OFS_RAW_HI   = 8'h24;
    localparam logic [7:0] OFS_RAW_LO   = 8'h28;
    localparam logic [7:0] OFS_DBGEN    = 8'h2C;
    localparam logic [7:0] OFS_PAUSE    = 8'h30;
    localparam logic [7:0] OFS_IRQ_RAW  = 8'h34;
    localparam logic [7:0] OFS_IRQ_EN   = 8'h38;
    localparam logic [7:0] OFS_IRQ_FRC  = 8'h3C;
    localparam logic [7:0] OFS_IRQ_STAT = 8'h40;

    typedef enum logic {
        ALM_IDLE  = 1'b0,
        ALM_ARMED = 1'b1
    } alm_state_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DBG_N  = 2,
    localparam int unsigned CNT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pause_i,
    input  logic [DBG_N-1:0]  dbg_en_i,
    input  logic [DBG_N-1:0]  dbg_act_i,
    input  logic              ld_lo_i,
    input  logic              ld_hi_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              latch_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [WORD_W-1:0] hold_hi_o,
    output logic              halted_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] lo_stage_q;
    logic [WORD_W-1:0] hold_q;

    always_comb begin
        halted_o = pause_i | (|(dbg_en_i & dbg_act_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            lo_stage_q <= '0;
            hold_q     <= '0;
        end else begin
            if (ld_lo_i) begin
                lo_stage_q <= wdata_i;
            end
            if (ld_hi_i) begin
                cnt_q <= {wdata_i, lo_stage_q};
            end else if (tick_i && !halted_o) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (latch_i) begin
                hold_q <= cnt_q[CNT_W-1:WORD_W];
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign hold_hi_o = hold_q;
endmodule

// File: rtl/tmr_alarm.sv
module tmr_alarm
    import tmr_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              disarm_i,
    input  logic [WORD_W-1:0] now_i,
    output logic              armed_o,
    output logic              fire_o
);
    alm_state_e        state_q, state_d;
    logic [WORD_W-1:0] target_q;
    logic              hit;

    assign hit = (target_q == now_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ALM_IDLE;
            target_q <= '0;
        end else begin
            state_q <= state_d;
            if (wr_i) begin
                target_q <= wdata_i;
            end
        end
    end

    // next state: arm, retarget, fire, cancel
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE: begin
                if (wr_i) state_d = ALM_ARMED;
            end
            ALM_ARMED: begin
                if (wr_i)          state_d = ALM_ARMED;
                else if (hit)      state_d = ALM_IDLE;
                else if (disarm_i) state_d = ALM_IDLE;
            end
            default: state_d = ALM_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        armed_o = 1'b0;
        fire_o  = 1'b0;
        unique case (state_q)
            ALM_IDLE: begin
                armed_o = 1'b0;
                fire_o  = 1'b0;
            end
            ALM_ARMED: begin
                armed_o = 1'b1;
                fire_o  = hit && !wr_i;
            end
            default: begin
                armed_o = 1'b0;
                fire_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire_i,
    input  logic         clr_wr_i,
    input  logic         en_wr_i,
    input  logic         frc_wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] en_o,
    output logic [N-1:0] frc_o,
    output logic [N-1:0] irq_o
);
    logic [N-1:0] raw_q, en_q, frc_q;
    logic [N-1:0] clr_mask;

    assign clr_mask = clr_wr_i ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            en_q  <= '0;
            frc_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_mask) | fire_i;
            if (en_wr_i)  en_q  <= wdata_i;
            if (frc_wr_i) frc_q <= wdata_i;
        end
    end

    assign raw_o = raw_q;
    assign en_o  = en_q;
    assign frc_o = frc_q;
    assign irq_o = (raw_q | frc_q) & en_q;
endmodule

// File: rtl/tmr_alarm_timer.sv
module tmr_alarm_timer
    import tmr_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_ALARM = 4,
    parameter int unsigned DBG_N   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [DBG_N-1:0]   dbg_active_i,
    input  logic [7:0]         bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [WORD_W-1:0]  bus_wdata_i,
    input  logic               bus_rd_i,
    output logic [WORD_W-1:0]  bus_rdata_o,
    output logic [N_ALARM-1:0] irq_o
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0]   cnt_w;
    logic [WORD_W-1:0]  hold_hi_w;
    logic               halted_w;
    logic               pause_q;
    logic [DBG_N-1:0]   dbg_en_q;
    logic [N_ALARM-1:0] armed_w, fire_w, raw_w, inte_w, frc_w;
    logic               disarm_wr;

    logic wr_hi, wr_lo, rd_lo;
    assign wr_hi     = bus_wr_i && (bus_addr_i == OFS_WR_HI);
    assign wr_lo     = bus_wr_i && (bus_addr_i == OFS_WR_LO);
    assign rd_lo     = bus_rd_i && (bus_addr_i == OFS_RD_LO);
    assign disarm_wr = bus_wr_i && (bus_addr_i == OFS_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pause_q  <= 1'b0;
            dbg_en_q <= '0;
        end else if (bus_wr_i) begin
            if (bus_addr_i == OFS_PAUSE) pause_q  <= bus_wdata_i[0];
            if (bus_addr_i == OFS_DBGEN) dbg_en_q <= bus_wdata_i[DBG_N-1:0];
        end
    end

    tmr_counter #(.WORD_W(WORD_W), .DBG_N(DBG_N)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .pause_i   (pause_q),
        .dbg_en_i  (dbg_en_q),
        .dbg_act_i (dbg_active_i),
        .ld_lo_i   (wr_lo),
        .ld_hi_i   (wr_hi),
        .wdata_i   (bus_wdata_i),
        .latch_i   (rd_lo),
        .cnt_o     (cnt_w),
        .hold_hi_o (hold_hi_w),
        .halted_o  (halted_w)
    );

    for (genvar k = 0; k < N_ALARM; k++) begin : g_alarm
        localparam logic [7:0] ALM_ADDR = OFS_ALARM0 + 8'(4 * k);
        logic alm_wr;
        assign alm_wr = bus_wr_i && (bus_addr_i == ALM_ADDR);
        tmr_alarm #(.WORD_W(WORD_W)) u_alm (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (alm_wr),
            .wdata_i  (bus_wdata_i),
            .disarm_i (disarm_wr && bus_wdata_i[k]),
            .now_i    (cnt_w[WORD_W-1:0]),
            .armed_o  (armed_w[k]),
            .fire_o   (fire_w[k])
        );
    end

    tmr_irq #(.N(N_ALARM)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire_w),
        .clr_wr_i (bus_wr_i && (bus_addr_i == OFS_IRQ_RAW)),
        .en_wr_i  (bus_wr_i && (bus_addr_i == OFS_IRQ_EN)),
        .frc_wr_i (bus_wr_i && (bus_addr_i == OFS_IRQ_FRC)),
        .wdata_i  (bus_wdata_i[N_ALARM-1:0]),
        .raw_o    (raw_w),
        .en_o     (inte_w),
        .frc_o    (frc_w),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            case (bus_addr_i)
                OFS_RD_HI:    bus_rdata_o = hold_hi_w;
                OFS_RD_LO:    bus_rdata_o = cnt_w[WORD_W-1:0];
                OFS_RAW_HI:   bus_rdata_o = cnt_w[CNT_W-1:WORD_W];
                OFS_RAW_LO:   bus_rdata_o = cnt_w[WORD_W-1:0];
                OFS_ARMED:    bus_rdata_o[N_ALARM-1:0] = armed_w;
                OFS_DBGEN:    bus_rdata_o[DBG_N-1:0]   = dbg_en_q;
                OFS_PAUSE:    bus_rdata_o[0]           = pause_q;
                OFS_IRQ_RAW:  bus_rdata_o[N_ALARM-1:0] = raw_w;
                OFS_IRQ_EN:   bus_rdata_o[N_ALARM-1:0] = inte_w;
                OFS_IRQ_FRC:  bus_rdata_o[N_ALARM-1:0] = frc_w;
                OFS_IRQ_STAT: bus_rdata_o[N_ALARM-1:0] = irq_o;
                default:      bus_rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_alarm_timer_chk.sv
module tmr_alarm_timer_chk
    import tmr_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned N_ALARM = 4,
    localparam int unsigned CNT_W  = 2 * WORD_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic [7:0]         bus_addr_i,
    input logic               bus_wr_i,
    input logic               bus_rd_i,
    input logic [CNT_W-1:0]   cnt,
    input logic [WORD_W-1:0]  hold_hi,
    input logic               halted,
    input logic [N_ALARM-1:0] armed,
    input logic [N_ALARM-1:0] fire,
    input logic [N_ALARM-1:0] raw,
    input logic [N_ALARM-1:0] inte,
    input logic [N_ALARM-1:0] irq
);
    logic load_hi;
    assign load_hi = bus_wr_i && (bus_addr_i == OFS_WR_HI);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !halted && !load_hi) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R5 and R6: any active pause freezes the counter
    p_pause_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !load_hi) |=> $stable(cnt));

    p_low_read_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == OFS_RD_LO) |=> (hold_hi == $past(cnt[CNT_W-1:WORD_W])));

    p_irq_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~inte) == '0));

    for (genvar k = 0; k < N_ALARM; k++) begin : g_chk
        localparam logic [7:0] A = OFS_ALARM0 + 8'(4 * k);
        p_write_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && bus_addr_i == A) |=> armed[k]);
        p_fire_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fire[k] |=> (!armed[k] && raw[k]));
        p_fire_needs_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fire[k] |-> armed[k]);
    end
endmodule

bind tmr_alarm_timer tmr_alarm_timer_chk #(.WORD_W(WORD_W), .N_ALARM(N_ALARM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .bus_addr_i (bus_addr_i),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .cnt        (cnt_w),
    .hold_hi    (hold_hi_w),
    .halted     (halted_w),
    .armed      (armed_w),
    .fire       (fire_w),
    .raw        (raw_w),
    .inte       (inte_w),
    .irq        (irq_o)
);

// File: tb/tmr_alarm_timer_tb.sv
module tmr_alarm_timer_tb;
    import tmr_pkg::*;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  dbg_act = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tmr_alarm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dbg_active_i(dbg_act),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rd_i(rd),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic load_cnt(input logic [63:0] v);
        bus_write(OFS_WR_LO, v[31:0]);
        bus_write(OFS_WR_HI, v[63:32]);
    endtask

    task automatic raw_cnt(output logic [63:0] v);
        logic [31:0] lo, hi;
        bus_read(OFS_RAW_LO, lo);
        bus_read(OFS_RAW_HI, hi);
        v = {hi, lo};
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] v, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 8'h08; a <= 8'h40; a += 4) begin
            bus_read(8'(a), d);
            check("R1 reset read", {32'h0, d}, 64'h0);
        end
        check("R1 irq after reset", {60'h0, irq}, 64'h0);

        // R3 load, R2 sweep across the 32-bit carry
        base = 64'h0000_0002_FFFF_FFFC;
        load_cnt(base);
        raw_cnt(v);
        check("R3 load counter", v, base);
        for (int k = 1; k <= 8; k++) begin
            pulse(1);
            raw_cnt(v);
            check("R2 increment", v, base + 64'(k));
        end
        tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
        raw_cnt(v);
        check("R2 continuous ticks", v, base + 64'd13);

        // R4 coherent read via latch
        load_cnt(64'h0000_0001_FFFF_FFFF);
        bus_read(OFS_RD_LO, d);
        check("R4 low read", {32'h0, d}, 64'hFFFF_FFFF);
        pulse(1);
        raw_cnt(v);
        check("R4 raw live", v, 64'h0000_0002_0000_0000);
        bus_read(OFS_RD_HI, d);
        check("R4 latched high kept", {32'h0, d}, 64'h1);
        bus_read(OFS_RD_LO, d);
        bus_read(OFS_RD_HI, d);
        check("R4 latched high refreshed", {32'h0, d}, 64'h2);

        // R5 pause
        load_cnt(64'd500);
        bus_write(OFS_PAUSE, 32'h1);
        pulse(4);
        raw_cnt(v);
        check("R5 paused hold", v, 64'd500);
        bus_write(OFS_PAUSE, 32'h0);
        pulse(1);
        raw_cnt(v);
        check("R5 resumed", v, 64'd501);

        // R6 debug pause
        bus_write(OFS_DBGEN, 32'h1);
        dbg_act = 2'b10;
        pulse(2);
        raw_cnt(v);
        check("R6 unmatched debug counts", v, 64'd503);
        dbg_act = 2'b01;
        pulse(3);
        raw_cnt(v);
        check("R6 matched debug holds", v, 64'd503);
        dbg_act = 2'b00;
        bus_write(OFS_DBGEN, 32'h0);

        // R7 R8 R11 R12: sweep each alarm, target wraps the low word
        for (int k = 0; k < 4; k++) begin
            base = {32'(k + 7), 32'hFFFF_FFFE};
            load_cnt(base);
            bus_write(OFS_IRQ_EN, 32'(1 << k));
            bus_write(OFS_ALARM0 + 8'(4 * k), 32'h0000_0001);
            bus_read(OFS_ARMED, d);
            check("R7 armed bit", {32'h0, d}, 64'(1 << k));
            pulse(2);
            bus_read(OFS_IRQ_RAW, d);
            check("R8 no early fire", {32'h0, d}, 64'h0);
            pulse(1);
            bus_read(OFS_IRQ_RAW, d);
            check("R8 raw set on match", {32'h0, d}, 64'(1 << k));
            check("R12 irq on fire", {60'h0, irq}, 64'(1 << k));
            bus_read(OFS_ARMED, d);
            check("R8 self disarm", {32'h0, d}, 64'h0);
            bus_write(OFS_IRQ_RAW, 32'h0);
            bus_read(OFS_IRQ_RAW, d);
            check("R11 write zero keeps raw", {32'h0, d}, 64'(1 << k));
            bus_write(OFS_IRQ_RAW, 32'(1 << k));
            bus_read(OFS_IRQ_RAW, d);
            check("R11 raw cleared", {32'h0, d}, 64'h0);
            check("R12 irq cleared", {60'h0, irq}, 64'h0);
        end

        // R9 disarm
        bus_write(OFS_IRQ_EN, 32'hF);
        load_cnt(64'd100);
        bus_write(OFS_ALARM0 + 8'd8, 32'd105);
        bus_write(OFS_ARMED, 32'h4);
        bus_read(OFS_ARMED, d);
        check("R9 disarmed", {32'h0, d}, 64'h0);
        pulse(8);
        bus_read(OFS_IRQ_RAW, d);
        check("R9 no fire after disarm", {32'h0, d}, 64'h0);
        check("R9 irq quiet", {60'h0, irq}, 64'h0);

        // R10 write in match cycle wins
        load_cnt(64'd200);
        bus_write(OFS_ALARM0 + 8'd4, 32'd201);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        addr = OFS_ALARM0 + 8'd4; wdata = 32'd209; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        bus_read(OFS_ARMED, d);
        check("R10 still armed", {32'h0, d}, 64'h2);
        bus_read(OFS_IRQ_RAW, d);
        check("R10 no fire", {32'h0, d}, 64'h0);
        pulse(8);
        bus_read(OFS_IRQ_RAW, d);
        check("R10 new target fires", {32'h0, d}, 64'h2);
        bus_write(OFS_IRQ_RAW, 32'hF);

        // R12 masking and force
        bus_write(OFS_IRQ_EN, 32'h0);
        raw_cnt(v);
        bus_write(OFS_ALARM0 + 8'd12, v[31:0] + 32'd1);
        pulse(1);
        bus_read(OFS_IRQ_RAW, d);
        check("R12 raw without enable", {32'h0, d}, 64'h8);
        check("R12 masked irq", {60'h0, irq}, 64'h0);
        bus_write(OFS_IRQ_EN, 32'h8);
        check("R12 enabled irq", {60'h0, irq}, 64'h8);
        bus_write(OFS_IRQ_RAW, 32'h8);
        bus_write(OFS_IRQ_FRC, 32'h3);
        check("R12 force masked", {60'h0, irq}, 64'h0);
        bus_write(OFS_IRQ_EN, 32'hF);
        check("R12 force irq", {60'h0, irq}, 64'h3);
        bus_read(OFS_IRQ_STAT, d);
        check("R12 status read", {32'h0, d}, 64'h3);
        bus_write(OFS_IRQ_EN, 32'h1);
        check("R12 partial enable", {60'h0, irq}, 64'h1);
        bus_write(OFS_IRQ_FRC, 32'h0);
        check("R12 force off", {60'h0, irq}, 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule